// File: doc/BRIEF.md
# Burst Preamble Phase Picker

This block recovers bit timing at the start of each burst without a tracking loop. Each bit period brings in one vector of samples, and each sample was taken at a different offset inside the bit, or on a different clock phase. While the burst's alternating preamble is arriving, the block treats each vector position as a candidate recovered bit stream. It counts how often that stream disagrees with an ideal alternating pattern. Both polarities of the pattern are counted, and the smaller count is kept.

After a fixed number of training bits, the block compares the candidates. It picks the one with the fewest disagreements, and a tie goes to the position nearest the centre of the bit. It then freezes that choice and raises a lock flag. For the rest of the burst it emits the chosen sample as the retimed bit. If even the best candidate is too noisy, lock is withheld and a fresh training window begins. A burst-start pulse discards all state and starts training again.

Top module: `burst_phase_picker`

## Requirements
- R1: After reset, `locked` and `bit_valid` are low and `phase_sel` is 0.
- R2: Training takes exactly TRAIN_BITS (default 16) accepted samples, an accepted sample being a cycle with `samp_valid` high. `locked` rises in the cycle after the last of them and never earlier.
- R3: A candidate's score is the smaller of two counts taken over the window. The first is its mismatches against a pattern that expects 1 on the first training sample of the window and alternates after that. The second is its mismatches against the inverse of that pattern.
- R4: The phase selected at lock is one whose score is the lowest among all candidates.
- R5: Among candidates with equal lowest score, the one whose index is nearest (N_PHASES-1)/2, rounded down, wins. If two are equally near, the lower index wins.
- R6: If every score exceeds MAX_ERR (default 2), `locked` stays low, all counts restart, and the next accepted sample counts as the first of a new window.
- R7: While locked, each accepted sample produces `bit_out` = `samp[phase_sel]` with `bit_valid` high for one cycle, in the following cycle. `phase_sel` stays constant until the next burst start.
- R8: A `burst_start` pulse drops `locked` and `bit_valid` in the next cycle and restarts training. A sample presented in the same cycle as the pulse is ignored and does not count toward the window.
- R9: `bit_valid` is never high while `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_start | input | 1 | One-cycle pulse marking a new burst |
| samp_valid | input | 1 | A new sample vector (one bit period) is present |
| samp | input | N_PHASES | One sample per phase for the current bit |
| bit_out | output | 1 | Retimed bit from the frozen phase |
| bit_valid | output | 1 | `bit_out` holds a new bit this cycle |
| locked | output | 1 | Phase choice frozen for this burst |
| phase_sel | output | $clog2(N_PHASES) | Chosen phase index, meaningful while locked |

## Verification
The bench goes after several corner cases, and each one exposes a particular mistake:
- Ties among perfect candidates. A picker without the centre preference would settle on phase 0 or on the last phase.
- A preamble of inverted polarity. A scorer that knows only one polarity would give every clean phase the worst score.
- An all-noisy window. A design that skipped the threshold would lock onto garbage, and a design with a bad restart would lock after the wrong number of samples.
- A burst start in the middle of training, with a sample in the same cycle. A design that kept partial counts or consumed that sample would lock one or more samples early.
- Seeded random bursts with per-phase error rates, checked against a bench-side scoring model. These catch off-by-one errors in the count and wrong selection order.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
   typedef enum logic {
      PAT_ONE_FIRST  = 1'b0,
      PAT_ZERO_FIRST = 1'b1
   } pat_pol_e;

   function automatic int unsigned dist_to_mid(input int unsigned idx, input int unsigned n);
      int unsigned mid;
      mid = (n - 1) / 2;
      return (idx > mid) ? (idx - mid) : (mid - idx);
   endfunction
endpackage

// File: rtl/bpp_phase_scorer.sv
module bpp_phase_scorer #(
   parameter int unsigned TRAIN_BITS = 16,
   parameter int unsigned SW         = $clog2(TRAIN_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic          bit_in,
   input  logic          idx_odd,
   output logic [SW-1:0] score
);
   import bpp_pkg::*;

   logic [SW-1:0] miss_a_q, miss_b_q, miss_a_d, miss_b_d;
   logic          want_a;

   // pattern A expects 1 on even window positions, pattern B the inverse
   assign want_a = (PAT_ONE_FIRST == pat_pol_e'(idx_odd));

   always_comb begin
      miss_a_d = miss_a_q;
      miss_b_d = miss_b_q;
      if (en) begin
         if (bit_in != want_a) miss_a_d = miss_a_q + 1'b1;
         else                  miss_b_d = miss_b_q + 1'b1;
      end
      score = (miss_a_d < miss_b_d) ? miss_a_d : miss_b_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_a_q <= '0;
         miss_b_q <= '0;
      end else if (clr) begin
         miss_a_q <= '0;
         miss_b_q <= '0;
      end else if (en) begin
         miss_a_q <= miss_a_d;
         miss_b_q <= miss_b_d;
      end
   end

   // the two counts together never exceed the window length
   assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, miss_a_q} + {1'b0, miss_b_q}) <= (SW+1)'(TRAIN_BITS));
endmodule

// File: rtl/bpp_best_pick.sv
module bpp_best_pick #(
   parameter int unsigned N_PHASES = 5,
   parameter int unsigned SW       = 5,
   parameter int unsigned PW       = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
   input  logic [N_PHASES-1:0][SW-1:0] scores,
   output logic [PW-1:0]               best_idx,
   output logic [SW-1:0]               best_score
);
   import bpp_pkg::*;

   always_comb begin
      int unsigned best_dist;
      best_idx   = '0;
      best_score = scores[0];
      best_dist  = dist_to_mid(0, N_PHASES);
      // ascending scan: strict improvement needed, so equal distance keeps lower index
      for (int unsigned p = 1; p < N_PHASES; p++) begin
         if ((scores[p] < best_score) ||
             ((scores[p] == best_score) && (dist_to_mid(p, N_PHASES) < best_dist))) begin
            best_idx   = PW'(p);
            best_score = scores[p];
            best_dist  = dist_to_mid(p, N_PHASES);
         end
      end
   end
endmodule

// File: rtl/burst_phase_picker.sv
module burst_phase_picker #(
   parameter int unsigned N_PHASES   = 5,
   parameter int unsigned TRAIN_BITS = 16,
   parameter int unsigned MAX_ERR    = 2,
   localparam int unsigned PW        = (N_PHASES > 1) ? $clog2(N_PHASES) : 1,
   localparam int unsigned CW        = (TRAIN_BITS > 1) ? $clog2(TRAIN_BITS) : 1,
   localparam int unsigned SW        = $clog2(TRAIN_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                burst_start,
   input  logic                samp_valid,
   input  logic [N_PHASES-1:0] samp,
   output logic                bit_out,
   output logic                bit_valid,
   output logic                locked,
   output logic [PW-1:0]       phase_sel
);
   localparam logic [CW-1:0] LAST_IDX = CW'(TRAIN_BITS - 1);

   generate
      if (N_PHASES < 2)              begin : g_bad_phases  $error("N_PHASES must be at least 2");   end
      if (TRAIN_BITS < 2)            begin : g_bad_window  $error("TRAIN_BITS must be at least 2"); end
      if (MAX_ERR >= TRAIN_BITS / 2) begin : g_bad_thresh  $error("MAX_ERR must be below TRAIN_BITS/2"); end
   endgenerate

   logic [CW-1:0]               cnt_q;
   logic                        train_en, train_last, score_clr;
   logic [N_PHASES-1:0][SW-1:0] scores;
   logic [PW-1:0]               best_idx;
   logic [SW-1:0]               best_score;

   assign train_en   = samp_valid && !burst_start && !locked;
   assign train_last = train_en && (cnt_q == LAST_IDX);
   assign score_clr  = burst_start || train_last;

   genvar gp;
   generate
      for (gp = 0; gp < N_PHASES; gp++) begin : g_score
         bpp_phase_scorer #(.TRAIN_BITS(TRAIN_BITS), .SW(SW)) u_scorer (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (score_clr),
            .en      (train_en),
            .bit_in  (samp[gp]),
            .idx_odd (cnt_q[0]),
            .score   (scores[gp])
         );
      end
   endgenerate

   bpp_best_pick #(.N_PHASES(N_PHASES), .SW(SW), .PW(PW)) u_pick (
      .scores     (scores),
      .best_idx   (best_idx),
      .best_score (best_score)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         locked    <= 1'b0;
         phase_sel <= '0;
         bit_out   <= 1'b0;
         bit_valid <= 1'b0;
      end else begin
         bit_valid <= 1'b0;
         if (burst_start) begin
            cnt_q     <= '0;
            locked    <= 1'b0;
            phase_sel <= '0;
         end else if (samp_valid && locked) begin
            bit_out   <= samp[phase_sel];
            bit_valid <= 1'b1;
         end else if (train_last) begin
            cnt_q <= '0;
            if (best_score <= SW'(MAX_ERR)) begin
               locked    <= 1'b1;
               phase_sel <= best_idx;
            end
         end else if (train_en) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assert_valid_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> locked);
   assert_sel_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !burst_start) |=> $stable(phase_sel));
   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_start |=> (!locked && !bit_valid));
   assert_lock_on_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(samp_valid));
   assert_lock_quality_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> ($past(best_score) <= SW'(MAX_ERR)));
   assert_sel_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_sel < PW'(N_PHASES));
endmodule

// File: tb/burst_phase_picker_tb_top.sv
`timescale 1ns/1ps
module burst_phase_picker_tb_top;
   localparam int N  = 5;
   localparam int TB = 16;
   localparam int ME = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         burst_start = 1'b0;
   logic         samp_valid = 1'b0;
   logic [N-1:0] samp = '0;
   logic         bit_out, bit_valid, locked;
   logic [2:0]   phase_sel;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // model state
   int m_a[N];
   int m_b[N];
   int m_k = 0;
   bit m_lock = 1'b0;
   int m_sel = 0;

   always #2 clk = ~clk;

   burst_phase_picker dut_i (
      .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .samp_valid(samp_valid),
      .samp(samp), .bit_out(bit_out), .bit_valid(bit_valid), .locked(locked),
      .phase_sel(phase_sel)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int dist_mid(input int p);
      int mid = (N - 1) / 2;
      return (p > mid) ? p - mid : mid - p;
   endfunction

   function automatic int expected_pick(input int sc[N]);
      int b = 0;
      for (int p = 1; p < N; p++)
         if (sc[p] < sc[b] || (sc[p] == sc[b] && dist_mid(p) < dist_mid(b))) b = p;
      return b;
   endfunction

   task automatic model_clear();
      for (int p = 0; p < N; p++) begin m_a[p] = 0; m_b[p] = 0; end
      m_k = 0;
   endtask

   // R3/R4/R5/R6 model of one training sample
   task automatic model_train(input logic [N-1:0] v);
      int sc[N];
      int best;
      for (int p = 0; p < N; p++) begin
         if (v[p] == ((m_k % 2) == 0)) m_b[p]++; else m_a[p]++;
      end
      m_k++;
      if (m_k == TB) begin
         for (int p = 0; p < N; p++) sc[p] = (m_a[p] < m_b[p]) ? m_a[p] : m_b[p];
         best = expected_pick(sc);
         if (sc[best] <= ME) begin m_lock = 1'b1; m_sel = best; end
         model_clear();
      end
   endtask

   task automatic apply(input logic [N-1:0] v, input bit start);
      @(negedge clk);
      samp = v; samp_valid = 1'b1; burst_start = start;
      @(negedge clk);
      samp_valid = 1'b0; burst_start = 1'b0;
   endtask

   task automatic new_burst();
      @(negedge clk);
      burst_start = 1'b1;
      @(negedge clk);
      burst_start = 1'b0;
      m_lock = 1'b0; m_sel = 0; model_clear();
      check(locked == 1'b0 && bit_valid == 1'b0, "R8 start clears lock", locked, 0);
   endtask

   task automatic train(input logic [N-1:0] v);
      apply(v, 1'b0);
      model_train(v);
      check(locked == m_lock, "R2/R6 lock timing", locked, m_lock);
      check(bit_valid == 1'b0, "R9 no output during training", bit_valid, 0);
      if (m_lock) check(phase_sel == m_sel, "R4/R5 selected phase", phase_sel, m_sel);
   endtask

   task automatic data(input logic [N-1:0] v);
      apply(v, 1'b0);
      check(bit_valid == 1'b1 && bit_out == v[m_sel], "R7 retimed bit", bit_out, v[m_sel]);
      check(phase_sel == m_sel, "R7 phase frozen", phase_sel, m_sel);
   endtask

   function automatic logic [N-1:0] alt_vec(input int k, input bit pol);
      return {N{((k % 2) == 0) ^ pol}};
   endfunction

   initial begin
      #800000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] v;
      int qual[N];
      bit pol;
      void'($urandom(32'd20240611));
      model_clear();
      #9;
      check(locked == 1'b0 && bit_valid == 1'b0 && phase_sel == 0, "R1 reset state", locked, 0);
      rst_n = 1'b1;

      // all phases perfect: tie resolved to centre (R5)
      new_burst();
      for (int k = 0; k < TB; k++) train(alt_vec(k, 1'b0));
      check(phase_sel == 2, "R5 centre wins full tie", phase_sel, 2);
      for (int k = 0; k < 6; k++) data(N'($urandom));

      // inverted preamble polarity still scores zero (R3)
      new_burst();
      for (int k = 0; k < TB; k++) train(alt_vec(k, 1'b1));
      check(locked == 1'b1 && phase_sel == 2, "R3 inverted polarity locks", phase_sel, 2);

      // phases 0,1 stuck, 2 one error, 3,4 clean: 3 nearer centre (R4, R5)
      new_burst();
      for (int k = 0; k < TB; k++) begin
         v = alt_vec(k, 1'b0);
         v[1:0] = 2'b11;
         if (k == 5) v[2] = ~v[2];
         train(v);
      end
      check(phase_sel == 3, "R4/R5 lowest score, nearer centre", phase_sel, 3);

      // all noisy: four errors each, no lock, then retraining (R6)
      new_burst();
      for (int k = 0; k < TB; k++) train((k < 4) ? ~alt_vec(k, 1'b0) : alt_vec(k, 1'b0));
      check(locked == 1'b0, "R6 no lock when all noisy", locked, 0);
      for (int k = 0; k < TB - 1; k++) train(alt_vec(k, 1'b0));
      check(locked == 1'b0, "R6 restart needs full window", locked, 0);
      train(alt_vec(TB - 1, 1'b0));
      check(locked == 1'b1, "R6 lock after fresh window", locked, 1);

      // burst start mid-training with a sample in the same cycle (R8)
      new_burst();
      for (int k = 0; k < 8; k++) train(alt_vec(k, 1'b0));
      apply(alt_vec(8, 1'b0), 1'b1);
      m_lock = 1'b0; model_clear();
      check(locked == 1'b0, "R8 start mid-training", locked, 0);
      for (int k = 0; k < TB; k++) train(alt_vec(k, 1'b1));
      check(locked == 1'b1, "R8 lock after full fresh window", locked, 1);
      data(N'($urandom));
      new_burst();

      // seeded random bursts
      for (int b = 0; b < 40; b++) begin
         new_burst();
         pol = 1'($urandom);
         for (int p = 0; p < N; p++) begin
            case ($urandom % 4)
               0: qual[p] = 0;
               1: qual[p] = 8;
               2: qual[p] = 25;
               default: qual[p] = 50;
            endcase
         end
         for (int k = 0; k < 4 * TB && !m_lock; k++) begin
            for (int p = 0; p < N; p++)
               v[p] = (((k % 2) == 0) ^ pol) ^ (($urandom % 100) < qual[p]);
            train(v);
         end
         if (m_lock) for (int k = 0; k < 5; k++) data(N'($urandom));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule